// File: doc/BRIEF.md
# Synthesizer Calibration Trigger Controller

This block decides when the frequency synthesizer gets recalibrated and runs the calibration window. The radio's state machine feeds it synthesizer turn-on and turn-off events, the current operating mode, a manual calibrate strobe, a channel-change pulse and a conditions-changed pulse. A two-bit policy field picks whether calibration starts by itself when the synthesizer comes up, when it goes down, or only on request.

Once started, the block raises a request to an external calibration engine for a fixed number of crystal-oscillator cycles, then gives a one-cycle done pulse and marks the stored calibration as valid. The valid flag survives sleep. It is dropped by a channel change or by the conditions-changed input. When a turn-on event starts a calibration, the synthesizer-ready output stays low until that calibration finishes.

Top module: `fs_cal_ctrl`

## Requirements
- R1: While reset is asserted and after it, calReq, calDone, calValid, synthReady and strobeErr are all 0.
- R2: With policy 2'b01, a synthOnEv pulse starts a calibration: calReq is 1 in the cycle after the pulse. Under any other policy, synthOnEv starts nothing.
- R3: With policy 2'b10, a synthOffEv pulse starts a calibration: calReq is 1 in the cycle after the pulse. Under any other policy, synthOffEv starts nothing.
- R4: A calStrobe pulse with mode 2'b00 (IDLE) starts a calibration under every policy. Mode encodings are 00 IDLE, 01 sleep, 10 active and 11 unused; the unused code counts as not IDLE.
- R5: A calStrobe pulse with mode other than 2'b00 starts nothing. It raises strobeErr for exactly the one cycle after the pulse.
- R6: calReq stays high for exactly CAL_CYCLES cycles. In the cycle after the last one, calDone is 1 for one cycle and calValid is 1.
- R7: A chanChange or condChanged pulse makes calValid 0 in the next cycle. This takes priority over a calibration that completes at the same edge.
- R8: Changes of mode, including sleep and wake, leave calValid unchanged.
- R9: synthReady rises in the cycle after synthOnEv and falls in the cycle after synthOffEv. If the turn-on starts a calibration, synthReady stays 0 until the cycle in which calDone is 1.
- R10: Triggers that arrive while calReq is high are ignored. The window is not restarted or extended.
- R11: Policy 2'b11 behaves like policy 2'b00: only the IDLE strobe starts a calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Auto-calibration policy: 00 manual, 01 on turn-on, 10 on turn-off, 11 manual |
| mode | input | 2 | Radio mode: 00 IDLE, 01 sleep, 10 active |
| synthOnEv | input | 1 | One-cycle pulse when the synthesizer turns on |
| synthOffEv | input | 1 | One-cycle pulse when the synthesizer turns off |
| calStrobe | input | 1 | Manual calibrate strobe |
| chanChange | input | 1 | Pulse when a new channel frequency is selected |
| condChanged | input | 1 | Pulse when supply or temperature has drifted |
| calReq | output | 1 | Request to the calibration engine, high for CAL_CYCLES cycles |
| calDone | output | 1 | One-cycle completion pulse |
| calValid | output | 1 | Stored calibration is usable |
| synthReady | output | 1 | Synthesizer is on and not waiting for its turn-on calibration |
| strobeErr | output | 1 | One-cycle pulse for a strobe rejected outside IDLE |

## Verification
The assertions assume that synthOnEv and synthOffEv are never high in the same cycle. They also assume each event is a single-cycle pulse, because a held turn-on level would read as repeated triggers. The stimulus drives every event for exactly one cycle, one event at a time, and changes inputs only on the falling clock edge. Before each case the bench resets the block, or lets any running calibration finish, so that every trigger meets an idle timer unless the case is a deliberate retrigger.

// File: rtl/fs_cal_pkg.sv
package fs_cal_pkg;
  localparam logic [1:0] MODE_IDLE  = 2'b00;
  localparam logic [1:0] MODE_SLEEP = 2'b01;
  localparam logic [1:0] MODE_ACT   = 2'b10;

  localparam logic [1:0] POL_MANUAL = 2'b00;
  localparam logic [1:0] POL_ON     = 2'b01;
  localparam logic [1:0] POL_OFF    = 2'b10;

  typedef struct packed {
    logic start;
  } calCtl_t;
endpackage

// File: rtl/fs_cal_timer.sv
module fs_cal_timer
  import fs_cal_pkg::*;
#(
  parameter int CAL_CYCLES = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  calCtl_t ctl,
  output logic    busy,
  output logic    finish
);
  localparam int CNT_W = $clog2(CAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CAL_CYCLES);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)          remain <= '0;
    else if (ctl.start)  remain <= LOAD;
    else if (busy)       remain <= remain - 1'b1;
  end

  assign busy   = (remain != '0);
  assign finish = (remain == CNT_W'(1));
endmodule

// File: rtl/fs_cal_seq.sv
module fs_cal_seq
  import fs_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] policy,
  input  logic [1:0] mode,
  input  logic       synthOnEv,
  input  logic       synthOffEv,
  input  logic       calStrobe,
  input  logic       chanChange,
  input  logic       condChanged,
  input  logic       busy,
  input  logic       finish,
  output calCtl_t    ctl,
  output logic       calDone,
  output logic       calValid,
  output logic       synthReady,
  output logic       strobeErr
);
  logic trigOn, trigOff, trigMan, isIdle, startNow;
  logic synOnQ, holdQ;

  assign isIdle   = (mode == MODE_IDLE);
  assign trigOn   = synthOnEv  && (policy == POL_ON);
  assign trigOff  = synthOffEv && (policy == POL_OFF);
  assign trigMan  = calStrobe  && isIdle;
  assign startNow = !busy && (trigOn || trigOff || trigMan);
  assign ctl.start = startNow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      calDone   <= 1'b0;
      calValid  <= 1'b0;
      strobeErr <= 1'b0;
      synOnQ    <= 1'b0;
      holdQ     <= 1'b0;
    end else begin
      calDone   <= finish;
      strobeErr <= calStrobe && !isIdle;

      if (synthOnEv)       synOnQ <= 1'b1;
      else if (synthOffEv) synOnQ <= 1'b0;

      if (startNow && trigOn) holdQ <= 1'b1;
      else if (finish)        holdQ <= 1'b0;

      if (chanChange || condChanged) calValid <= 1'b0;
      else if (startNow)             calValid <= 1'b0;
      else if (finish)               calValid <= 1'b1;
    end
  end

  assign synthReady = synOnQ && !holdQ;
endmodule

// File: rtl/fs_cal_ctrl.sv
module fs_cal_ctrl
  import fs_cal_pkg::*;
#(
  parameter int CAL_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] policy,
  input  logic [1:0] mode,
  input  logic       synthOnEv,
  input  logic       synthOffEv,
  input  logic       calStrobe,
  input  logic       chanChange,
  input  logic       condChanged,
  output logic       calReq,
  output logic       calDone,
  output logic       calValid,
  output logic       synthReady,
  output logic       strobeErr
);
  calCtl_t ctl;
  logic busy, finish;

  fs_cal_seq u_seq (
    .clk(clk), .rst_n(rst_n), .policy(policy), .mode(mode),
    .synthOnEv(synthOnEv), .synthOffEv(synthOffEv), .calStrobe(calStrobe),
    .chanChange(chanChange), .condChanged(condChanged),
    .busy(busy), .finish(finish), .ctl(ctl),
    .calDone(calDone), .calValid(calValid),
    .synthReady(synthReady), .strobeErr(strobeErr)
  );

  fs_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .busy(busy), .finish(finish)
  );

  assign calReq = busy;
endmodule

// File: rtl/fs_cal_ctrl_chk.sv
module fs_cal_ctrl_chk #(
  parameter int CAL_CYCLES = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] policy,
  input logic [1:0] mode,
  input logic       synthOnEv,
  input logic       synthOffEv,
  input logic       calStrobe,
  input logic       chanChange,
  input logic       condChanged,
  input logic       calReq,
  input logic       calDone,
  input logic       calValid,
  input logic       synthReady,
  input logic       strobeErr
);
  localparam int W = $clog2(CAL_CYCLES + 2) + 1;
  logic [W-1:0] highCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      highCnt <= '0;
    else if (calReq) highCnt <= highCnt + 1'b1;
    else             highCnt <= '0;
  end

  p_req_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(calReq) |-> (highCnt == W'(CAL_CYCLES)));

  p_done_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(calReq) |-> calDone);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    calDone |=> !calDone);

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (calStrobe && mode != 2'b00) |=> strobeErr);

  p_valid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chanChange || condChanged) |=> !calValid);

  p_on_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (synthOnEv && policy == 2'b01 && !calReq) |=> (calReq && !synthReady));

  p_manual_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (calStrobe && mode == 2'b00) |=> calReq);
endmodule

bind fs_cal_ctrl fs_cal_ctrl_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (.*);

// File: tb/test_fs_cal_ctrl.sv
`timescale 1ns/1ps
module test_fs_cal_ctrl;
  localparam int C = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] policy, mode;
  logic synthOnEv, synthOffEv, calStrobe, chanChange, condChanged;
  logic calReq, calDone, calValid, synthReady, strobeErr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fs_cal_ctrl #(.CAL_CYCLES(C)) i_fs_cal_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 1'b0; policy = 2'b00; mode = 2'b00;
    synthOnEv = 0; synthOffEv = 0; calStrobe = 0; chanChange = 0; condChanged = 0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  // kind 0 = turn-on event, 1 = turn-off event, 2 = strobe
  task automatic runCase(input int pol, input int kind, input int md);
    bit exp, errExp;
    string tag;
    doReset();
    if (kind == 1) begin
      synthOnEv = 1; tick(); synthOnEv = 0; tick();
    end
    policy = 2'(pol); mode = 2'(md);
    case (kind)
      0: synthOnEv = 1;
      1: synthOffEv = 1;
      default: calStrobe = 1;
    endcase
    tick();
    synthOnEv = 0; synthOffEv = 0; calStrobe = 0;
    exp    = (kind == 0) ? (pol == 1) : (kind == 1) ? (pol == 2) : (md == 0);
    errExp = (kind == 2) && (md != 0);
    tag = (kind == 0) ? ((pol == 3) ? "R11 on-event" : "R2 on-event")
        : (kind == 1) ? ((pol == 3) ? "R11 off-event" : "R3 off-event")
        : (md == 0 ? "R4 idle strobe" : "R5 strobe outside idle");
    chk(tag, calReq, exp);
    chk({tag, " strobeErr"}, strobeErr, errExp);
    if (kind == 0) chk("R9 ready after on", synthReady, !exp);
    if (kind == 1) chk("R9 ready after off", synthReady, 0);
    if (exp) begin
      for (int i = 1; i < C; i++) begin
        tick(); chk("R6 calReq held", calReq, 1);
      end
      tick();
      chk("R6 calReq low at end", calReq, 0);
      chk("R6 calDone", calDone, 1);
      chk("R6 calValid", calValid, 1);
      if (kind == 0) chk("R9 ready at done", synthReady, 1);
      tick();
      chk("R6 done one cycle", calDone, 0);
    end else begin
      tick();
      chk({tag, " no cal"}, calReq, 0);
      chk("R5 err one cycle", strobeErr, 0);
      chk({tag, " valid stays"}, calValid, 0);
    end
  endtask

  task automatic manualCal();
    mode = 2'b00; calStrobe = 1; tick(); calStrobe = 0;
    repeat (C) tick();
  endtask

  initial begin
    doReset();
    rst_n = 1'b0; tick();
    chk("R1 calReq", calReq, 0);   chk("R1 calDone", calDone, 0);
    chk("R1 calValid", calValid, 0); chk("R1 synthReady", synthReady, 0);
    chk("R1 strobeErr", strobeErr, 0);
    rst_n = 1'b1; tick();
    chk("R1 after reset", {calReq, calDone, calValid, synthReady, strobeErr}, 0);

    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 3; k++)
        for (int m = 0; m < 4; m++)
          runCase(p, k, m);

    // R7: channel change and condition change clear valid
    doReset();
    manualCal();
    chk("R7 valid before clear", calValid, 1);
    chanChange = 1; tick(); chanChange = 0;
    chk("R7 chanChange clears", calValid, 0);
    manualCal();
    condChanged = 1; tick(); condChanged = 0;
    chk("R7 condChanged clears", calValid, 0);
    // R7 priority at completion edge
    calStrobe = 1; tick(); calStrobe = 0;
    repeat (C - 1) tick();
    chk("R7 last req cycle", calReq, 1);
    condChanged = 1; tick(); condChanged = 0;
    chk("R7 done still pulses", calDone, 1);
    chk("R7 clear wins over completion", calValid, 0);

    // R8: sleep and wake keep valid
    manualCal();
    mode = 2'b01; repeat (10) tick();
    chk("R8 valid in sleep", calValid, 1);
    mode = 2'b10; tick(); mode = 2'b00; tick();
    chk("R8 valid after wake", calValid, 1);

    // R10: retrigger while busy is ignored
    doReset();
    calStrobe = 1; tick(); calStrobe = 0;
    tick();
    calStrobe = 1; tick(); calStrobe = 0;
    repeat (C - 3) tick();
    chk("R10 still in window", calReq, 1);
    tick();
    chk("R10 window not extended", calReq, 0);
    chk("R10 done at original end", calDone, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule